// File: doc/BRIEF.md
# Nanosecond Time-of-Day Counter with Fractional Rate Control

This block keeps a 44-bit count of nanoseconds for precision-time use. Each reference clock it adds a programmable increment to a 73-bit accumulator. The upper 44 bits are the nanosecond count and the lower 29 bits are a fraction. The increment is an unsigned fixed-point number with 3 integer bits and 29 fractional bits. The host trims the counter's rate by changing the increment. Writing zero freezes time. The count wraps to zero after 2^44 - 1.

The host reaches the counter through a 32-bit word interface with four word offsets:
- 0x0 is the low nanosecond slice.
- 0x4 is the middle slice.
- 0x8 is the high slice.
- 0xC is the increment.

The high slice is read in data bits [7:0] but written from data bits [15:8]. Each slice write takes effect on its own. The usual way to set the time is to zero the increment, write the three slices, and then restore the increment.

A small control state machine has two states, HALT and RUN:
- HALT → RUN (transition `start`): an increment write with a nonzero value.
- RUN → HALT (transition `stop`): an increment write of zero.
- Any other cycle keeps the current state (`hold`).

In RUN the accumulator advances on every cycle that carries no slice write.

Top module: `nco_tod_timer`

## Requirements
- R1: After reset the count, the fraction and the increment are all zero, and reads of every offset return zero.
- R2: In every cycle where the increment is nonzero and no slice is written, the increment is added to {count, fraction}. Its 3 integer bits add at count bit 0, and carries from the fraction pass into count bit 0.
- R3: While the increment is zero, the count does not change.
- R4: A write to offset 0x0 replaces count bits [3:0] with write data [3:0], clears the fraction, and leaves count bits [43:4] unchanged.
- R5: A write to offset 0x4 replaces count bits [35:4] with write data [31:0] and leaves the other count bits and the fraction unchanged.
- R6: A write to offset 0x8 replaces count bits [43:36] with write data [15:8]; write data [7:0] has no effect.
- R7: A read request is answered one cycle later, with `rdata_valid` high for exactly that cycle. The returned data is the state as it stood when the request was sampled. Offset 0x0 returns count[3:0] in bits [3:0], 0x4 returns count[35:4], and 0x8 returns count[43:36] in bits [7:0]. Unused bits read as zero.
- R8: The count is not advanced in a cycle that writes a time slice; advancing resumes on the next cycle.
- R9: The count wraps modulo 2^44, so the value after 0xFFFFFFFFFFF is 0.
- R10: The increment register loads all 32 bits of write data at offset 0xC, and a read of offset 0xC returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Write request |
| host_rd | input | 1 | Read request |
| host_addr | input | 4 | Byte offset; bits [3:2] select the word |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid with `rdata_valid` |
| rdata_valid | output | 1 | Read data strobe, one cycle after the request |
| tod_ns | output | 44 | Current nanosecond count |

## Verification
The bench targets the following corner cases:
- **Asymmetric high-slice lanes.** The written value carries garbage in its low byte. A design that took the write from the read lane would load 0x77 instead of 0xAB.
- **Fraction clear on a low-slice write.** Half-nanosecond steps leave a fraction pending before the low slice is rewritten. A design that kept the fraction would show the low nibble one higher after the next half-step.
- **No advance on a slice-write cycle.** A middle-slice write lands while the counter runs. A design that also advanced in that cycle would read the low nibble 4 ns too high.
- **Wrap at 2^44.** The count starts at 0xFFFFFFFFFFE and takes one 4 ns step. It must land on 2 with zero upper slices; a wider or saturating counter would show otherwise.

// File: rtl/nco_tod_pkg.sv
package nco_tod_pkg;

    // Word select taken from address bits [3:2]
    typedef enum logic [1:0] {
        SEL_LOW  = 2'd0,
        SEL_MID  = 2'd1,
        SEL_HIGH = 2'd2,
        SEL_INC  = 2'd3
    } word_sel_e;

    // Control states of the rate engine
    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // One-hot write strobes decoded from a host write
    typedef struct packed {
        logic low;
        logic mid;
        logic high;
        logic inc;
    } wr_strobe_t;

endpackage

// File: rtl/nco_tod_regs.sv
module nco_tod_regs
    import nco_tod_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NS_W   = 44,
    parameter int LOW_W  = 4,
    parameter int MID_W  = 32,
    parameter int HIGH_W = 8,
    parameter int INC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  word_sel_e         word_sel,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [NS_W-1:0]   count,
    output wr_strobe_t        strobe,
    output logic [INC_W-1:0]  inc_q,
    output logic [DATA_W-1:0] rdata_q,
    output logic              rvalid_q
);

    localparam int HIGH_LSB = LOW_W + MID_W;

    logic [DATA_W-1:0] rd_mux;

    // Write decode
    always_comb begin
        strobe = '0;
        if (host_wr) begin
            unique case (word_sel)
                SEL_LOW:  strobe.low  = 1'b1;
                SEL_MID:  strobe.mid  = 1'b1;
                SEL_HIGH: strobe.high = 1'b1;
                SEL_INC:  strobe.inc  = 1'b1;
            endcase
        end
    end

    // Increment register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_q <= '0;
        end else if (strobe.inc) begin
            inc_q <= host_wdata[INC_W-1:0];
        end
    end

    // Read selection; unused bits read as zero
    always_comb begin
        rd_mux = '0;
        unique case (word_sel)
            SEL_LOW:  rd_mux = DATA_W'(count[LOW_W-1:0]);
            SEL_MID:  rd_mux = DATA_W'(count[LOW_W +: MID_W]);
            SEL_HIGH: rd_mux = DATA_W'(count[HIGH_LSB +: HIGH_W]);
            SEL_INC:  rd_mux = DATA_W'(inc_q);
        endcase
    end

    // Registered read response, one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= host_rd;
            if (host_rd) begin
                rdata_q <= rd_mux;
            end
        end
    end

    p_rvalid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> rvalid_q);
    p_rvalid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> !rvalid_q);
    p_inc_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && word_sel == SEL_INC) |=> inc_q == $past(host_wdata[INC_W-1:0]));

endmodule

// File: rtl/nco_tod_ctrl.sv
module nco_tod_ctrl
    import nco_tod_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int INC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_strobe_t        strobe,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              adv_en
);

    run_state_e state_q, state_nx;
    logic       slice_wr;

    assign slice_wr = strobe.low | strobe.mid | strobe.high;

    // Transitions: start (HALT->RUN), stop (RUN->HALT), hold otherwise
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_HALT: if (strobe.inc && host_wdata[INC_W-1:0] != '0) state_nx = ST_RUN;
            ST_RUN:  if (strobe.inc && host_wdata[INC_W-1:0] == '0) state_nx = ST_HALT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_nx;
        end
    end

    // Outputs
    always_comb begin
        adv_en = 1'b0;
        unique case (state_q)
            ST_HALT: adv_en = 1'b0;
            ST_RUN:  adv_en = !slice_wr;
        endcase
    end

    p_no_adv_on_slice_r8: assert property (@(posedge clk) disable iff (!rst_n)
        slice_wr |-> !adv_en);

endmodule

// File: rtl/nco_tod_accum.sv
module nco_tod_accum
    import nco_tod_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int NS_W        = 44,
    parameter int LOW_W       = 4,
    parameter int MID_W       = 32,
    parameter int HIGH_W      = 8,
    parameter int HIGH_WR_LSB = 8,
    parameter int INC_W       = 32,
    parameter int FRAC_W      = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_strobe_t        strobe,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [INC_W-1:0]  inc_q,
    input  logic              adv_en,
    output logic [NS_W-1:0]   count_q
);

    localparam int ACC_W    = NS_W + FRAC_W;
    localparam int HIGH_LSB = LOW_W + MID_W;

    logic [FRAC_W-1:0] frac_q, frac_nx;
    logic [NS_W-1:0]   count_nx;
    logic [ACC_W-1:0]  sum;

    // Fixed-point add; bit FRAC_W of the increment lines up with count bit 0
    assign sum = {count_q, frac_q} + ACC_W'(inc_q);

    always_comb begin
        count_nx = count_q;
        frac_nx  = frac_q;
        if (strobe.low) begin
            count_nx[LOW_W-1:0] = host_wdata[LOW_W-1:0];
            frac_nx             = '0;
        end else if (strobe.mid) begin
            count_nx[LOW_W +: MID_W] = host_wdata[MID_W-1:0];
        end else if (strobe.high) begin
            count_nx[HIGH_LSB +: HIGH_W] = host_wdata[HIGH_WR_LSB +: HIGH_W];
        end else if (adv_en) begin
            {count_nx, frac_nx} = sum;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            frac_q  <= '0;
        end else begin
            count_q <= count_nx;
            frac_q  <= frac_nx;
        end
    end

    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (count_q == '0 && frac_q == '0));
    p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_q == '0 && !strobe.low && !strobe.mid && !strobe.high) |=> $stable(count_q));
    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && inc_q != '0) |=> {count_q, frac_q} != $past({count_q, frac_q}));
    p_low_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe.low |=> (count_q[LOW_W-1:0] == $past(host_wdata[LOW_W-1:0]) && frac_q == '0
                        && count_q[NS_W-1:LOW_W] == $past(count_q[NS_W-1:LOW_W])));
    p_mid_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe.mid |=> (count_q[LOW_W +: MID_W] == $past(host_wdata[MID_W-1:0])
                        && count_q[LOW_W-1:0] == $past(count_q[LOW_W-1:0])));
    p_high_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe.high |=> count_q[HIGH_LSB +: HIGH_W] == $past(host_wdata[HIGH_WR_LSB +: HIGH_W]));

endmodule

// File: rtl/nco_tod_timer.sv
module nco_tod_timer
    import nco_tod_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 4,
    parameter int LOW_W       = 4,
    parameter int MID_W       = 32,
    parameter int HIGH_W      = 8,
    parameter int HIGH_WR_LSB = 8,
    parameter int INC_W       = 32,
    parameter int FRAC_W      = 29,
    localparam int NS_W       = LOW_W + MID_W + HIGH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              rdata_valid,
    output logic [NS_W-1:0]   tod_ns
);

    word_sel_e        word_sel;
    wr_strobe_t       strobe;
    logic [INC_W-1:0] inc_q;
    logic             adv_en;

    assign word_sel = word_sel_e'(host_addr[3:2]);

    nco_tod_regs #(
        .DATA_W(DATA_W), .NS_W(NS_W), .LOW_W(LOW_W),
        .MID_W(MID_W), .HIGH_W(HIGH_W), .INC_W(INC_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .word_sel(word_sel), .host_wdata(host_wdata), .count(tod_ns),
        .strobe(strobe), .inc_q(inc_q), .rdata_q(host_rdata), .rvalid_q(rdata_valid)
    );

    nco_tod_ctrl #(
        .DATA_W(DATA_W), .INC_W(INC_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .strobe(strobe),
        .host_wdata(host_wdata), .adv_en(adv_en)
    );

    nco_tod_accum #(
        .DATA_W(DATA_W), .NS_W(NS_W), .LOW_W(LOW_W), .MID_W(MID_W),
        .HIGH_W(HIGH_W), .HIGH_WR_LSB(HIGH_WR_LSB), .INC_W(INC_W), .FRAC_W(FRAC_W)
    ) u_accum (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .host_wdata(host_wdata),
        .inc_q(inc_q), .adv_en(adv_en), .count_q(tod_ns)
    );

    p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tod_ns) == '1 && $past(adv_en) && $past(inc_q[INC_W-1:FRAC_W]) != '0)
        |-> tod_ns < NS_W'(8));

endmodule

// File: tb/nco_tod_timer_tb.sv
module nco_tod_timer_tb;

    localparam logic [3:0] A_LOW = 4'h0, A_MID = 4'h4, A_HIGH = 4'h8, A_INC = 4'hC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        rdata_valid;
    logic [43:0] tod_ns;

    int checks = 0, failures = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          done = 1'b0;

    always #10 clk = ~clk;

    nco_tod_timer u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rdata_valid(rdata_valid), .tod_ns(tod_ns)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Each task starts at a negedge and consumes exactly one rising edge
    task automatic wr(logic [3:0] a, logic [31:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
        host_rd = 1'b1; host_addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare each response against the scoreboard
    always @(negedge clk) begin
        if (rst_n && rdata_valid) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R7 actual=unexpected response expected=none");
            end else begin
                check(tag_q.pop_front(), 64'(host_rdata), 64'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        fork
            begin
                repeat (5000) @(posedge clk);
                if (!done) begin
                    checks++; failures++;
                    $display("FAIL watchdog actual=timeout expected=finish");
                    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                    $finish;
                end
            end
        join_none

        idle(3);
        rst_n = 1'b1;
        check("R1 tod after reset", 64'(tod_ns), 64'd0);
        check("R7 no valid without request", 64'(rdata_valid), 64'd0);
        rd(A_LOW, 32'h0, "R1 low reads 0");
        rd(A_MID, 32'h0, "R1 mid reads 0");
        rd(A_HIGH, 32'h0, "R1 high reads 0");
        rd(A_INC, 32'h0, "R1 inc reads 0");
        idle(10);
        rd(A_MID, 32'h0, "R3 frozen with zero increment");

        // Slice loads while frozen
        wr(A_LOW, 32'hFFFF_FFF5);
        wr(A_MID, 32'h1234_5678);
        wr(A_HIGH, 32'h0000_AB77);
        idle(4);
        rd(A_LOW, 32'h5, "R4 low slice load");
        rd(A_MID, 32'h1234_5678, "R5 mid slice load");
        rd(A_HIGH, 32'hAB, "R6 high from bits 15:8");
        check("R6 tod composed", 64'(tod_ns), 64'hAB_1234_5678_5);

        // Nominal rate 4 ns/clock: 11 advances (10 idle + stop write)
        wr(A_INC, 32'h8000_0000);
        idle(10);
        wr(A_INC, 32'h0);
        rd(A_LOW, 32'h1, "R2 low after 11 steps of 4 ns");
        rd(A_MID, 32'h1234_567B, "R2 carry into mid");
        idle(5);
        rd(A_MID, 32'h1234_567B, "R3 held after stop");

        // Half-ns steps: 7 advances -> 3.5 ns
        wr(A_LOW, 32'h0);
        wr(A_MID, 32'h0);
        wr(A_HIGH, 32'h0);
        wr(A_INC, 32'h1000_0000);
        rd(A_INC, 32'h1000_0000, "R10 increment readback");
        idle(5);
        wr(A_INC, 32'h0);
        rd(A_LOW, 32'h3, "R2 fractional carry into bit 0");
        wr(A_LOW, 32'h0);
        wr(A_INC, 32'h1000_0000);
        wr(A_INC, 32'h0);
        rd(A_LOW, 32'h0, "R4 fraction cleared by low write");

        // Slice write while running: no advance on that cycle
        wr(A_LOW, 32'h0);
        wr(A_INC, 32'h8000_0000);
        wr(A_MID, 32'h100);
        wr(A_INC, 32'h0);
        rd(A_LOW, 32'h4, "R8 no advance on slice write");
        rd(A_MID, 32'h100, "R8 mid kept after write");

        // Wrap at 2^44
        wr(A_HIGH, 32'h0000_FF00);
        wr(A_MID, 32'hFFFF_FFFF);
        wr(A_LOW, 32'hE);
        check("R9 tod near top", 64'(tod_ns), 64'hFFF_FFFF_FFFE);
        wr(A_INC, 32'h8000_0000);
        wr(A_INC, 32'h0);
        rd(A_LOW, 32'h2, "R9 wrapped low");
        rd(A_MID, 32'h0, "R9 wrapped mid");
        rd(A_HIGH, 32'h0, "R9 wrapped high");
        rd(A_INC, 32'h0, "R10 zero readback");

        idle(3);
        check("R7 all responses seen", 64'(exp_q.size()), 64'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule